// File: doc/BRIEF.md
# Multi-Bank Open-Row Command Scheduler

This block sits between a request source and a DRAM-style device. It takes read and write requests, one at a time, on a valid/ready port. Each request carries a 31-bit address. The block turns each request into a short series of precharge, activate and column (read or write) commands on a 21-bit command/address bus. It keeps one open-row register for each of 32 banks. A request that falls on the row already open in its bank goes straight to the column command. A request to a closed bank first opens the row. A request that conflicts with the open row first closes the bank and then opens the new row.

Each bank has its own down-counters that hold back every command until its cycle-counted spacing is met:
- activate to column command (`T_RCD`),
- precharge to activate (`T_RP`),
- activate to precharge (`T_RAS`).

A read strobe marks the cycle in which read data would return, `CL` cycles after the read command. Two counters report how many requests were classed as hits and how many as misses.

The controller is a four-state machine:
- **IDLE**: `req_ready` is high. On an accepted request it moves to ACCESS on a hit, to CLOSE when the bank holds another row, and to OPEN when the bank is closed.
- **CLOSE**: waits for the activate-to-precharge spacing, issues precharge, then moves to OPEN.
- **OPEN**: waits for the precharge-to-activate spacing, issues activate, then moves to ACCESS.
- **ACCESS**: waits for the activate-to-column spacing, issues read or write, then returns to IDLE.

Top module: `dram_cmd_sched`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` and `rd_valid` are 0, both counters are 0 and every bank is closed, so the first request to any bank produces no precharge.
- R2: Address fields are bank group = `req_addr[30:28]`, bank = `req_addr[27:26]`, row = `req_addr[25:10]` and column = `req_addr[9:0]`. The bank index is {bank group, bank}, 0 to 31.
- R3: Command codes are precharge = 0, activate = 1, read = 2 and write = 3. The address is sent in two phases:
  - activate drives `cmd_addr` = {bank index, row};
  - read and write drive {bank index, 6'b0, column};
  - precharge drives {bank index, 16'b0}.
  At most one command is issued per cycle.
- R4: A request whose row matches its bank's open row issues only the column command and increments `hit_count`.
- R5: A request to a closed bank issues activate, then the column command, and increments `miss_count`. The two counters never both change in one cycle.
- R6: A request to a bank that holds a different row issues precharge, activate and the column command, in that order, and increments `miss_count`.
- R7: Opening or closing a row in one bank leaves the open rows of all other banks unchanged.
- R8: A column command that follows an activate is issued exactly `T_RCD` cycles after it.
- R9: An activate that follows a precharge is issued exactly `T_RP` cycles after it.
- R10: A precharge to a bank is issued no earlier than `T_RAS` cycles after that bank's last activate.
- R11: `rd_valid` pulses for one cycle exactly `CL` cycles after each read command, and never after a write.
- R12: Requests are served in arrival order. `req_ready` is 0 from the cycle after acceptance until the cycle after that request's column command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Scheduler can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 31 | Request address |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_code | output | 2 | Command kind (R3 encoding) |
| cmd_addr | output | 21 | Row phase or column phase address |
| rd_valid | output | 1 | Read data return strobe |
| hit_count | output | 16 | Requests classed as row hits |
| miss_count | output | 16 | Requests classed as row misses |

## Verification
The scoreboard is driven through three request patterns, and each one tells a different case apart:
- **Repeated accesses to one open row** separate hit handling, which must issue a lone column command, from needless reopening.
- **Accesses that spread over distant banks**, including bank 31 with all-ones row and column fields, show that the banks hold rows independently and that the address fields are packed into each command phase.
- **Conflicting rows in the same bank, sent back to back**, force the precharge path. The activate-to-precharge wait can then be observed, along with the exact precharge, activate and column spacings and the read strobe delay.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        CMD_PRE = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLOSE,
        ST_OPEN,
        ST_ACCESS
    } st_e;
endpackage

// File: rtl/open_row_table.sv
module open_row_table #(
    parameter int NB    = 32,
    parameter int ROW_W = 16,
    localparam int BI_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_en,
    input  logic             pre_en,
    input  logic [BI_W-1:0]  upd_bank,
    input  logic [ROW_W-1:0] upd_row,
    input  logic [BI_W-1:0]  lk_bank,
    output logic             lk_open,
    output logic [ROW_W-1:0] lk_row
);
    logic [NB-1:0] open_q;
    logic [ROW_W-1:0] row_q [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (act_en && upd_bank == BI_W'(b)) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= upd_row;
            end else if (pre_en && upd_bank == BI_W'(b)) begin
                open_q[b] <= 1'b0;
            end
        end

        // R7
        other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((act_en || pre_en) && upd_bank != BI_W'(b)) |=> $stable(row_q[b]) && $stable(open_q[b]));
    end

    assign lk_open = open_q[lk_bank];
    assign lk_row  = row_q[lk_bank];
endmodule

// File: rtl/bank_timers.sv
module bank_timers #(
    parameter int NB    = 32,
    parameter int T_RCD = 4,
    parameter int T_RP  = 4,
    parameter int T_RAS = 10,
    localparam int BI_W = $clog2(NB),
    localparam int TMAX = (T_RAS > T_RCD) ? ((T_RAS > T_RP) ? T_RAS : T_RP)
                                          : ((T_RCD > T_RP) ? T_RCD : T_RP),
    localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            act_en,
    input  logic            pre_en,
    input  logic            col_en,
    input  logic [BI_W-1:0] bank,
    output logic            can_pre,
    output logic            can_act,
    output logic            can_col
);
    logic [CW-1:0] rcd_q [NB];
    logic [CW-1:0] rp_q  [NB];
    logic [CW-1:0] ras_q [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic sel;
        assign sel = (bank == BI_W'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rcd_q[b] <= '0;
                rp_q[b]  <= '0;
                ras_q[b] <= '0;
            end else begin
                if (act_en && sel) begin
                    rcd_q[b] <= CW'(T_RCD - 1);
                    ras_q[b] <= CW'(T_RAS - 1);
                end else begin
                    if (rcd_q[b] != '0) rcd_q[b] <= rcd_q[b] - 1'b1;
                    if (ras_q[b] != '0) ras_q[b] <= ras_q[b] - 1'b1;
                end
                if (pre_en && sel)
                    rp_q[b] <= CW'(T_RP - 1);
                else if (rp_q[b] != '0)
                    rp_q[b] <= rp_q[b] - 1'b1;
            end
        end

        // R8
        col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (col_en && sel) |-> rcd_q[b] == '0);
        // R9
        act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_en && sel) |-> rp_q[b] == '0);
        // R10
        pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_en && sel) |-> ras_q[b] == '0);
    end

    assign can_col = (rcd_q[bank] == '0);
    assign can_act = (rp_q[bank]  == '0);
    assign can_pre = (ras_q[bank] == '0);
endmodule

// File: rtl/rd_return_pipe.sv
module rd_return_pipe #(
    parameter int CL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    output logic rd_valid
);
    logic [CL-1:0] sr_q;

    if (CL == 1) begin : g_one
        always_ff @(posedge clk) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= rd_en;
        end
    end else begin : g_many
        always_ff @(posedge clk) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[CL-2:0], rd_en};
        end
    end

    assign rd_valid = sr_q[CL-1];
endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched
    import sched_pkg::*;
#(
    parameter int BG_W   = 3,
    parameter int BA_W   = 2,
    parameter int ROW_W  = 16,
    parameter int COL_W  = 10,
    parameter int CL     = 4,
    parameter int T_RCD  = 4,
    parameter int T_RP   = 4,
    parameter int T_RAS  = 10,
    parameter int CNT_W  = 16,
    localparam int BI_W   = BG_W + BA_W,
    localparam int NB     = 1 << BI_W,
    localparam int ADDR_W = BI_W + ROW_W + COL_W,
    localparam int BUS_W  = BI_W + ROW_W,
    localparam int PAD_W  = ROW_W - COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              cmd_valid,
    output logic [1:0]        cmd_code,
    output logic [BUS_W-1:0]  cmd_addr,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    st_e st_q, st_d;

    logic             q_write;
    logic [BI_W-1:0]  q_bank;
    logic [ROW_W-1:0] q_row;
    logic [COL_W-1:0] q_col;

    logic [BI_W-1:0]  in_bank;
    logic [ROW_W-1:0] in_row;
    logic             lk_open;
    logic [ROW_W-1:0] lk_row;
    logic             accept, is_hit;
    logic             can_pre, can_act, can_col;
    logic             issue_pre, issue_act, issue_col, issue_rd, issue_wr;

    assign in_bank = req_addr[ADDR_W-1 -: BI_W];
    assign in_row  = req_addr[COL_W +: ROW_W];
    assign accept  = req_valid && (st_q == ST_IDLE);
    assign is_hit  = lk_open && (lk_row == in_row);

    open_row_table #(.NB(NB), .ROW_W(ROW_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_en   (issue_act),
        .pre_en   (issue_pre),
        .upd_bank (q_bank),
        .upd_row  (q_row),
        .lk_bank  (in_bank),
        .lk_open  (lk_open),
        .lk_row   (lk_row)
    );

    bank_timers #(.NB(NB), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) u_timers (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_en  (issue_act),
        .pre_en  (issue_pre),
        .col_en  (issue_col),
        .bank    (q_bank),
        .can_pre (can_pre),
        .can_act (can_act),
        .can_col (can_col)
    );

    rd_return_pipe #(.CL(CL)) u_rdpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (issue_rd),
        .rd_valid (rd_valid)
    );

    // state register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            q_write <= 1'b0;
            q_bank  <= '0;
            q_row   <= '0;
            q_col   <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                q_write <= req_write;
                q_bank  <= in_bank;
                q_row   <= in_row;
                q_col   <= req_addr[COL_W-1:0];
            end
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid) st_d = is_hit ? ST_ACCESS : (lk_open ? ST_CLOSE : ST_OPEN);
            ST_CLOSE:  if (can_pre) st_d = ST_OPEN;
            ST_OPEN:   if (can_act) st_d = ST_ACCESS;
            ST_ACCESS: if (can_col) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        issue_pre = 1'b0;
        issue_act = 1'b0;
        issue_col = 1'b0;
        cmd_code  = CMD_PRE;
        cmd_addr  = {q_bank, {ROW_W{1'b0}}};
        unique case (st_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_CLOSE:  issue_pre = can_pre;
            ST_OPEN: begin
                issue_act = can_act;
                cmd_code  = CMD_ACT;
                cmd_addr  = {q_bank, q_row};
            end
            ST_ACCESS: begin
                issue_col = can_col;
                cmd_code  = q_write ? CMD_WR : CMD_RD;
                cmd_addr  = {q_bank, {PAD_W{1'b0}}, q_col};
            end
            default: ;
        endcase
    end

    assign issue_rd  = issue_col && !q_write;
    assign issue_wr  = issue_col && q_write;
    assign cmd_valid = issue_pre || issue_act || issue_col;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else if (accept) begin
            if (is_hit) hit_count  <= hit_count + 1'b1;
            else        miss_count <= miss_count + 1'b1;
        end
    end

    // R12
    one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    // R4
    hit_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_hit) |=> (st_q == ST_ACCESS));
    // R3
    single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({issue_pre, issue_act, issue_rd, issue_wr}));
    // R5
    count_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count != $past(hit_count)) |-> (miss_count == $past(miss_count)));
endmodule

// File: tb/sim_dram_cmd_sched.sv
module sim_dram_cmd_sched;
    localparam int CL = 4, T_RCD = 4, T_RP = 4, T_RAS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [30:0] req_addr = '0;
    logic        cmd_valid;
    logic [1:0]  cmd_code;
    logic [20:0] cmd_addr;
    logic        rd_valid;
    logic [15:0] hit_count, miss_count;

    always #5 clk = ~clk;

    dram_cmd_sched #(.CL(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .rd_valid(rd_valid),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    typedef struct packed {
        logic [1:0]  code;
        logic [20:0] addr;
    } exp_t;

    exp_t exp_q[$];
    int   rd_q[$];
    int   checks = 0, fails = 0, cyc = 0;
    int   exp_hits = 0, exp_miss = 0;
    logic        m_open [32];
    logic [15:0] m_row  [32];
    int   last_act [32];
    int   last_cyc = 0;
    logic [1:0] last_code = 2'd2;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            exp_t e;
            int   bk;
            bk = int'(cmd_addr[20:16]);
            if (exp_q.size() == 0) begin
                chk(0, "R12 unexpected command", cmd_code, 0);
            end else begin
                e = exp_q.pop_front();
                chk(cmd_code == e.code, "R3/R4/R5/R6 command code", cmd_code, e.code);
                chk(cmd_addr == e.addr, "R2/R3 command address", cmd_addr, e.addr);
            end
            if (cmd_code == 2'd1 && last_code == 2'd0)
                chk(cyc - last_cyc == T_RP, "R9 precharge to activate", cyc - last_cyc, T_RP);
            if (cmd_code[1] && last_code == 2'd1)
                chk(cyc - last_cyc == T_RCD, "R8 activate to column", cyc - last_cyc, T_RCD);
            if (cmd_code == 2'd0)
                chk(cyc - last_act[bk] >= T_RAS, "R10 activate to precharge", cyc - last_act[bk], T_RAS);
            if (cmd_code == 2'd1) last_act[bk] = cyc;
            if (cmd_code == 2'd2) rd_q.push_back(cyc + CL);
            last_cyc  = cyc;
            last_code = cmd_code;
        end
        if (rst_n && rd_valid) begin
            if (rd_q.size() == 0) chk(0, "R11 unexpected rd_valid", cyc, -1);
            else begin
                int t;
                t = rd_q.pop_front();
                chk(cyc == t, "R11 read strobe cycle", cyc, t);
            end
        end
    end

    // driver
    task automatic send(input bit wr, input int bg, input int ba, input int row, input int col);
        logic [4:0]  bk;
        logic [15:0] r;
        logic [9:0]  c;
        bk = {3'(bg), 2'(ba)};
        r  = 16'(row);
        c  = 10'(col);
        if (m_open[bk] && m_row[bk] == r) begin
            exp_hits++;
        end else begin
            exp_miss++;
            if (m_open[bk]) exp_q.push_back({2'd0, bk, 16'd0});
            exp_q.push_back({2'd1, bk, r});
        end
        exp_q.push_back({wr ? 2'd3 : 2'd2, bk, 6'd0, c});
        m_open[bk] = 1'b1;
        m_row[bk]  = r;
        req_write = wr;
        req_addr  = {bk, r, c};
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R12 ready low after accept", req_ready, 0);
    endtask

    task automatic drain();
        int n = 0;
        while ((exp_q.size() != 0 || rd_q.size() != 0 || !req_ready) && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_open[i] = 1'b0;
            m_row[i] = '0;
            last_act[i] = -1000;
        end
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R1
                chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
                chk(cmd_valid == 1'b0, "R1 no command after reset", cmd_valid, 0);
                chk(rd_valid == 1'b0, "R1 no strobe after reset", rd_valid, 0);
                chk(hit_count == 0 && miss_count == 0, "R1 counters zero", hit_count + miss_count, 0);

                send(0, 0, 0, 5, 3);            // R5 closed bank
                send(0, 0, 0, 5, 7);            // R4 hit
                send(1, 0, 0, 5, 1);            // R4 write hit
                send(0, 2, 1, 100, 9);          // R7 another bank
                send(0, 0, 0, 5, 512);          // R7 bank 0 still open
                drain();
                chk(hit_count == 16'(exp_hits), "R4 hit count", hit_count, exp_hits);
                send(1, 0, 0, 6, 2);            // R6 conflict
                send(0, 0, 0, 7, 4);            // R6/R10 back-to-back conflict
                send(0, 7, 3, 16'hFFFF, 10'h3FF); // R2 top fields
                send(1, 7, 3, 0, 0);            // R6 conflict bank 31
                send(0, 2, 1, 100, 11);         // R7 bank 9 untouched
                drain();
                chk(exp_q.size() == 0, "R12 all commands seen", exp_q.size(), 0);
                chk(hit_count == 16'(exp_hits), "R4 final hit count", hit_count, exp_hits);
                chk(miss_count == 16'(exp_miss), "R5/R6 final miss count", miss_count, exp_miss);
            end
            begin
                repeat (20000) @(posedge clk);
                chk(0, "watchdog expired", cyc, 0);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule